// File: doc/BRIEF.md
# Audio Master/Bit/Frame Clock Divider

This block turns a single module audio clock into the three timing references a serial audio port needs: a master-clock rate, a bit clock and a left/right frame clock. Everything stays in the module clock domain. The master rate appears as a one-cycle clock-enable pulse. The bit clock and the frame clock appear as registered square waves, each with a one-cycle strobe that a serializer can shift on.

An 8-bit configuration word sets the timing. Bits 3:0 select the master divide ratio. Bits 6:4 select the bit-clock ratio, which divides the master (oversampling) rate. Bit 7 gates the master-clock pulse output. Software picks a legal combination: the bit-clock ratio equals the oversampling factor divided by twice the word length.

While `run_i` is low the block is idle and the configuration word is copied continuously. While running, a new word is taken only at a frame boundary, so every frame on the wire has uniform timing. The frame clock spends `WORD_BITS` bit-clock periods in each half.

Top module: `audclk_divider`

## Requirements
- R1: Bit-clock code (cfg bits 6:4) values 0,1,2,3,4,5 give a bit-clock period of 2,4,6,8,12,16 master periods respectively.
- R2: Master code (cfg bits 3:0) values 0..7 give master ratios 1,2,4,6,8,12,16,24. With the enable set, `mclk_ce_o` pulses once every ratio module-clock cycles. Ratio 1 asserts it on every cycle.
- R3: When cfg bit 7 is 0, `mclk_ce_o` stays low. The bit clock keeps its period.
- R4: Bit-clock codes 6 and 7 act as ratio 16. Master codes 8 to 15 act as ratio 24.
- R5: `bclk_o` has a 50% duty cycle. It is high for exactly half of every period.
- R6: `lrclk_o` changes only on a bit-clock falling edge, after every `WORD_BITS` bit-clock periods. `frame_o` pulses in the cycle `lrclk_o` first reads low after being high. A full frame is 2×`WORD_BITS` bit-clock periods.
- R7: While running, a configuration change is applied only at the next frame boundary. While idle, the configuration is taken directly.
- R8: While `run_i` is low, `bclk_o` and `lrclk_o` read 0, and `mclk_ce_o`, `bclk_fall_o` and `frame_o` stay low.
- R9: `bclk_fall_o` is high exactly in the cycle where `bclk_o` first reads 0 after being 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module audio clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Enable clock generation; low holds all dividers idle |
| cfg_i | input | 8 | [3:0] master code, [6:4] bit-clock code, [7] master pulse enable |
| mclk_ce_o | output | 1 | One-cycle pulse per master period |
| bclk_o | output | 1 | Bit clock level |
| bclk_fall_o | output | 1 | Strobe on bit-clock falling edge |
| lrclk_o | output | 1 | Frame clock level, low for the first word |
| frame_o | output | 1 | Strobe at the start of each frame |

## Verification
The assertions assume that `cfg_i` is either stable for a whole frame or allowed to change only as R7 describes. They also assume that `run_i` may drop at any cycle, so that the counters restart from zero rather than from a partial state. The stimulus sets `cfg_i` while the block is idle and waits a few cycles before raising `run_i`. The one mid-run change is made deliberately in the middle of a frame, to exercise the deferred load.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

  localparam int RATIO_W = 5;

  typedef struct packed {
    logic       mclk_en;
    logic [2:0] bsel;
    logic [3:0] msel;
  } audclk_cfg_t;

  function automatic logic [RATIO_W-1:0] bclk_ratio(input logic [2:0] code);
    case (code)
      3'd0:    bclk_ratio = RATIO_W'(2);
      3'd1:    bclk_ratio = RATIO_W'(4);
      3'd2:    bclk_ratio = RATIO_W'(6);
      3'd3:    bclk_ratio = RATIO_W'(8);
      3'd4:    bclk_ratio = RATIO_W'(12);
      default: bclk_ratio = RATIO_W'(16);
    endcase
  endfunction

  function automatic logic [RATIO_W-1:0] mclk_ratio(input logic [3:0] code);
    case (code)
      4'd0:    mclk_ratio = RATIO_W'(1);
      4'd1:    mclk_ratio = RATIO_W'(2);
      4'd2:    mclk_ratio = RATIO_W'(4);
      4'd3:    mclk_ratio = RATIO_W'(6);
      4'd4:    mclk_ratio = RATIO_W'(8);
      4'd5:    mclk_ratio = RATIO_W'(12);
      4'd6:    mclk_ratio = RATIO_W'(16);
      default: mclk_ratio = RATIO_W'(24);
    endcase
  endfunction

endpackage

// File: rtl/audclk_mdiv.sv
module audclk_mdiv #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [RW-1:0] ratio,
  output logic          tick
);
  logic [RW-1:0] cnt_q;
  logic          last;

  assign last = (cnt_q == ratio - RW'(1));
  assign tick = run && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (last)   cnt_q <= '0;
    else             cnt_q <= cnt_q + RW'(1);
  end

  // R2: the phase counter never leaves the selected ratio
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < ratio));

endmodule

// File: rtl/audclk_bgen.sv
module audclk_bgen #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [RW-1:0] ratio,
  output logic          fall_now,
  output logic          bclk_o,
  output logic          fall_o
);
  localparam int HW = RW - 1;

  logic [HW-1:0] half;
  logic [HW-1:0] cnt_q;
  logic          bclk_q;
  logic          edge_now;

  assign half     = ratio[RW-1:1];
  assign edge_now = run && tick && (cnt_q == half - HW'(1));
  assign fall_now = edge_now && bclk_q;
  assign bclk_o   = bclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
      fall_o <= 1'b0;
    end else if (!run) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      fall_o <= fall_now;
      if (edge_now) begin
        cnt_q  <= '0;
        bclk_q <= ~bclk_q;
      end else if (tick) begin
        cnt_q  <= cnt_q + HW'(1);
      end
    end
  end

  // R1: the bit clock only moves on a master tick
  p_toggle_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && (bclk_q != $past(bclk_q))) |-> $past(tick));

  // R5: half-period counter stays inside its window
  p_half_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < half));

  // R9: the strobe marks a true high-to-low transition
  p_fall_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> (!bclk_q && $past(bclk_q)));

endmodule

// File: rtl/audclk_lrgen.sv
module audclk_lrgen #(
  parameter int WORD_BITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fall_now,
  output logic frame_now,
  output logic lrclk_o,
  output logic frame_o
);
  localparam int BW = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;

  logic [BW-1:0] bit_q;
  logic          lr_q;
  logic          word_end;

  assign word_end  = run && fall_now && (bit_q == BW'(WORD_BITS - 1));
  assign frame_now = word_end && lr_q;
  assign lrclk_o   = lr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= '0;
      lr_q    <= 1'b0;
      frame_o <= 1'b0;
    end else if (!run) begin
      bit_q   <= '0;
      lr_q    <= 1'b0;
      frame_o <= 1'b0;
    end else begin
      frame_o <= frame_now;
      if (word_end) begin
        bit_q <= '0;
        lr_q  <= ~lr_q;
      end else if (fall_now) begin
        bit_q <= bit_q + BW'(1);
      end
    end
  end

  // R6: the frame clock moves only with a bit-clock falling edge
  p_lr_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && (lr_q != $past(lr_q))) |-> $past(fall_now));

  // R6: frame strobe follows the high-to-low frame transition
  p_frame_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_o |-> (!lr_q && $past(lr_q)));

endmodule

// File: rtl/audclk_divider.sv
module audclk_divider #(
  parameter int WORD_BITS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic [7:0] cfg_i,
  output logic       mclk_ce_o,
  output logic       bclk_o,
  output logic       bclk_fall_o,
  output logic       lrclk_o,
  output logic       frame_o
);
  import audclk_pkg::*;

  audclk_cfg_t          act_q;
  logic [RATIO_W-1:0]   m_ratio;
  logic [RATIO_W-1:0]   b_ratio;
  logic                 tick;
  logic                 fall_now;
  logic                 frame_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   act_q <= '0;
    else if (!run_i || frame_now) act_q <= audclk_cfg_t'(cfg_i);
  end

  assign m_ratio   = mclk_ratio(act_q.msel);
  assign b_ratio   = bclk_ratio(act_q.bsel);
  assign mclk_ce_o = tick && act_q.mclk_en;

  audclk_mdiv #(.RW(RATIO_W)) u_mdiv (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_i),
    .ratio (m_ratio),
    .tick  (tick)
  );

  audclk_bgen #(.RW(RATIO_W)) u_bgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_i),
    .tick     (tick),
    .ratio    (b_ratio),
    .fall_now (fall_now),
    .bclk_o   (bclk_o),
    .fall_o   (bclk_fall_o)
  );

  audclk_lrgen #(.WORD_BITS(WORD_BITS)) u_lrgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_i),
    .fall_now  (fall_now),
    .frame_now (frame_now),
    .lrclk_o   (lrclk_o),
    .frame_o   (frame_o)
  );

  // R7: while running, the active setting moves only at a frame boundary
  p_cfg_at_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_i) && (act_q != $past(act_q))) |-> $past(frame_now));

endmodule

// File: tb/audclk_divider_bench.sv
module audclk_divider_bench;
  localparam int WB = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_i = 1'b0;
  logic [7:0] cfg_i = 8'h80;
  logic       mclk_ce_o, bclk_o, bclk_fall_o, lrclk_o, frame_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  audclk_divider #(.WORD_BITS(WB)) u_audclk_divider (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .cfg_i(cfg_i),
    .mclk_ce_o(mclk_ce_o), .bclk_o(bclk_o), .bclk_fall_o(bclk_fall_o),
    .lrclk_o(lrclk_o), .frame_o(frame_o)
  );

  function automatic int bref(input int code);
    int t[8] = '{2, 4, 6, 8, 12, 16, 16, 16};
    return t[code];
  endfunction

  function automatic int mref(input int code);
    int t[8] = '{1, 2, 4, 6, 8, 12, 16, 24};
    return (code > 7) ? 24 : t[code];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic start(input logic [7:0] c);
    @(negedge clk);
    run_i = 1'b0;
    cfg_i = c;
    repeat (3) @(negedge clk);
    run_i = 1'b1;
  endtask

  task automatic wait_fall();
    @(negedge clk);
    while (!bclk_fall_o) @(negedge clk);
  endtask

  // period and high time between two falls; R9 edge check on the closing fall
  task automatic bclk_period(output int per, output int hi, output bit edge_ok);
    logic prev;
    wait_fall();
    per = 0; hi = 0; prev = bclk_o;
    do begin
      prev = bclk_o;
      @(negedge clk);
      per++;
      if (bclk_o) hi++;
    end while (!bclk_fall_o);
    edge_ok = prev && !bclk_o;
  endtask

  task automatic mclk_period(output int per);
    @(negedge clk);
    while (!mclk_ce_o) @(negedge clk);
    per = 0;
    do begin
      @(negedge clk);
      per++;
    end while (!mclk_ce_o);
  endtask

  task automatic t_reset();
    chk(!bclk_o && !lrclk_o, "R8 reset levels", {bclk_o, lrclk_o}, 0);
    chk(!mclk_ce_o && !bclk_fall_o && !frame_o, "R8 reset strobes",
        {mclk_ce_o, bclk_fall_o, frame_o}, 0);
  endtask

  task automatic t_bclk_codes();
    int per, hi; bit e;
    for (int b = 0; b < 6; b++) begin
      start({1'b1, 3'(b), 4'd0});
      bclk_period(per, hi, e);
      chk(per == bref(b), $sformatf("R1 bclk code %0d period", b), per, bref(b));
      chk(hi == bref(b) / 2, $sformatf("R5 bclk code %0d high", b), hi, bref(b) / 2);
      chk(e, "R9 fall strobe on edge", int'(e), 1);
    end
  endtask

  task automatic t_mclk_codes();
    int per, bp, hi; bit e;
    for (int m = 0; m < 8; m++) begin
      start({1'b1, 3'd0, 4'(m)});
      mclk_period(per);
      chk(per == mref(m), $sformatf("R2 mclk code %0d pulse spacing", m), per, mref(m));
      bclk_period(bp, hi, e);
      chk(bp == 2 * mref(m), $sformatf("R2 bclk over mclk code %0d", m), bp, 2 * mref(m));
    end
  endtask

  task automatic t_unused_codes();
    int per, hi; bit e;
    start({1'b1, 3'd6, 4'd0});
    bclk_period(per, hi, e);
    chk(per == 16, "R4 bclk code 6", per, 16);
    start({1'b1, 3'd7, 4'd0});
    bclk_period(per, hi, e);
    chk(per == 16, "R4 bclk code 7", per, 16);
    start({1'b1, 3'd0, 4'd8});
    mclk_period(per);
    chk(per == 24, "R4 mclk code 8", per, 24);
    start({1'b1, 3'd1, 4'd15});
    mclk_period(per);
    chk(per == 24, "R4 mclk code 15", per, 24);
    bclk_period(per, hi, e);
    chk(per == 96, "R4 bclk over mclk code 15", per, 96);
  endtask

  task automatic t_mclk_gate();
    int seen = 0, per, hi; bit e;
    start({1'b0, 3'd1, 4'd1});
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (mclk_ce_o) seen++;
    end
    chk(seen == 0, "R3 mclk pulses while disabled", seen, 0);
    bclk_period(per, hi, e);
    chk(per == 8, "R3 bclk kept while mclk gated", per, 8);
  endtask

  task automatic t_frame();
    int per = 0, hi = 0, falls = 0;
    start({1'b1, 3'd0, 4'd0});
    @(negedge clk);
    while (!frame_o) @(negedge clk);
    chk(!lrclk_o, "R6 lrclk low at frame strobe", lrclk_o, 0);
    do begin
      @(negedge clk);
      per++;
      if (lrclk_o) hi++;
      if (bclk_fall_o) falls++;
    end while (!frame_o);
    chk(per == 2 * WB * 2, "R6 frame length", per, 2 * WB * 2);
    chk(hi == WB * 2, "R6 lrclk high time", hi, WB * 2);
    chk(falls == 2 * WB, "R6 bit clocks per frame", falls, 2 * WB);
  endtask

  task automatic t_deferred_cfg();
    int per, hi; bit e;
    start({1'b1, 3'd0, 4'd0});
    @(negedge clk);
    while (!frame_o) @(negedge clk);
    wait_fall();
    wait_fall();
    cfg_i = {1'b1, 3'd1, 4'd0};
    bclk_period(per, hi, e);
    chk(per == 2, "R7 old ratio kept mid-frame", per, 2);
    @(negedge clk);
    while (!frame_o) @(negedge clk);
    bclk_period(per, hi, e);
    chk(per == 4, "R7 new ratio after frame", per, 4);
  endtask

  task automatic t_stop();
    int bad = 0;
    start({1'b1, 3'd0, 4'd1});
    repeat (30) @(negedge clk);
    run_i = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (bclk_o || lrclk_o || mclk_ce_o || bclk_fall_o || frame_o) bad++;
    end
    chk(bad == 0, "R8 idle after run drops", bad, 0);
  endtask

  initial begin
    #1_500_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_bclk_codes();
    t_mclk_codes();
    t_unused_codes();
    t_mclk_gate();
    t_frame();
    t_deferred_cfg();
    t_stop();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule